// File: doc/BRIEF.md
# Sequential Memory-Hard Mixing Controller

This block performs the memory-hard mixing stage of a password-style key stretching pipeline on a 1024-bit working state, treated as thirty-two 32-bit words (word k sits at bits 32k+31 down to 32k). It works in two phases of equal length. In the first phase it stores every intermediate state in an external single-port scratchpad, one entry per iteration, and advances the state by two calls to an external mixing core. In the second phase each iteration picks an entry with an index taken from the state itself. It folds that entry into the state with XOR and then makes the same two core calls.

Each iteration advances the state the same way. The low half (words 0 to 15) is first replaced by the core's result on the operand pair (low, high). The high half (words 16 to 31) is then replaced by the result on (high, new low). The mixing core and the scratchpad are both outside the block. The core is reached through a one-cycle start strobe and a one-cycle completion strobe that carries the result. The scratchpad returns read data a fixed, parameterised number of cycles after the read address. A host loads a state, pulses start, and collects the result when done pulses.

Top module: `romix_sequencer`

## Requirements
- R1: After reset, done is low, state_out is all zeros, and neither sp_we, sp_rd nor mix_start is asserted.
- R2: In the fill phase the controller writes the current state to entries 0, 1, ..., DEPTH-1, in that order and once each. Each write carries the state as it stands before that iteration's core calls. No write occurs in the second phase.
- R3: Each iteration makes two core calls. The first call's operands are (mix_x, mix_y) = (words 0..15, words 16..31), and its result replaces words 0..15. The second call's operands are (words 16..31, the new words 0..15), and its result replaces words 16..31.
- R4: A complete run issues exactly 4*DEPTH single-cycle mix_start pulses: two per iteration in each phase. No new call is started while one is outstanding, and no call start coincides with a scratchpad access.
- R5: The second phase makes exactly DEPTH reads. Each read address equals word 16 of the state after the previous iteration's core calls, ANDed with DEPTH-1 (its low log2(DEPTH) bits).
- R6: The data sampled for the XOR is the scratchpad output RD_LAT cycles after the cycle in which sp_rd and the address were presented.
- R7: When the run completes, state_out equals the state produced by DEPTH fill iterations followed by DEPTH read-XOR-mix iterations, applied to the state_in captured at start.
- R8: done is high for exactly one cycle at completion. state_out changes only in that cycle and holds its value through any later start until the next completion. A start received while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run with state_in (sampled only when idle) |
| state_in | input | STATE_W | Initial working state |
| state_out | output | STATE_W | Final working state, held until the next completion |
| done | output | 1 | One-cycle completion pulse |
| sp_addr | output | AW | Scratchpad entry address |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_rd | output | 1 | Scratchpad read strobe |
| sp_wdata | output | STATE_W | Scratchpad write data (current state) |
| sp_rdata | input | STATE_W | Scratchpad read data, valid RD_LAT cycles after sp_rd |
| mix_start | output | 1 | Start strobe for the mixing core |
| mix_x | output | HALF_W | First core operand (the half being replaced) |
| mix_y | output | HALF_W | Second core operand |
| mix_done | input | 1 | Core completion strobe |
| mix_z | input | HALF_W | Core result, valid with mix_done |

## Verification
The bench builds the controller with DEPTH = 16 and RD_LAT = 3. With these values a complete run of both phases takes a few hundred cycles, so several full runs fit in one test and can be compared against a reference model of the whole two-phase sequence. The depth of 16 makes the data-dependent read indices repeat and skip entries, and it checks the masking of word 16 to four bits. A latency of 3 exercises the multi-cycle counting variant of the read-wait timer. The bench's core model varies its response time from call to call, so the handshake is tested with more than one fixed delay.

// File: rtl/romix_pkg.sv
package romix_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WRITE,
      S_RREQ,
      S_RWAIT,
      S_CALL0,
      S_WAIT0,
      S_CALL1,
      S_WAIT1
   } seq_state_e;

   typedef enum logic {
      PH_FILL = 1'b0,
      PH_MIX  = 1'b1
   } seq_phase_e;

endpackage

// File: rtl/romix_index_pick.sv
module romix_index_pick #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 1024,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic [WORD_W-1:0] word,
   output logic [AW-1:0]     idx
);

   localparam logic [WORD_W-1:0] MASK = WORD_W'(DEPTH - 1);

   generate
      if (AW > WORD_W) begin : g_bad_width
         $error("romix_index_pick: address wider than the index word");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("romix_index_pick: DEPTH must be a power of two");
      end
   endgenerate

   logic [WORD_W-1:0] masked;
   assign masked = word & MASK;
   assign idx    = AW'(masked);

endmodule

// File: rtl/romix_lat_timer.sv
module romix_lat_timer #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic fire
);

   generate
      if (LAT < 1) begin : g_bad
         $error("romix_lat_timer: LAT must be at least 1");
      end else if (LAT == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fire <= 1'b0;
            else        fire <= go;
         end
      end else begin : g_count
         localparam int CW = $clog2(LAT + 1);
         logic [CW-1:0] cnt_q;
         logic          run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               run_q <= 1'b0;
            end else if (go) begin
               cnt_q <= CW'(1);
               run_q <= 1'b1;
            end else if (run_q) begin
               if (cnt_q == CW'(LAT)) run_q <= 1'b0;
               else                   cnt_q <= cnt_q + CW'(1);
            end
         end

         assign fire = run_q && (cnt_q == CW'(LAT));

         // R6: a new read is never requested while one is still in flight
         p_go_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            go |-> !run_q);
         // R6: exactly one sample point per request
         p_fire_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> !fire);
      end
   endgenerate

endmodule

// File: rtl/romix_sequencer.sv
module romix_sequencer
   import romix_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int NWORDS   = 32,
   parameter int DEPTH    = 1024,
   parameter int RD_LAT   = 2,
   parameter int IDX_WORD = NWORDS / 2,
   localparam int STATE_W = WORD_W * NWORDS,
   localparam int HALF_W  = STATE_W / 2,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [STATE_W-1:0] state_in,
   output logic [STATE_W-1:0] state_out,
   output logic               done,
   output logic [AW-1:0]      sp_addr,
   output logic               sp_we,
   output logic               sp_rd,
   output logic [STATE_W-1:0] sp_wdata,
   input  logic [STATE_W-1:0] sp_rdata,
   output logic               mix_start,
   output logic [HALF_W-1:0]  mix_x,
   output logic [HALF_W-1:0]  mix_y,
   input  logic               mix_done,
   input  logic [HALF_W-1:0]  mix_z
);

   generate
      if ((NWORDS % 2) != 0) begin : g_bad_words
         $error("romix_sequencer: NWORDS must be even");
      end
      if (IDX_WORD >= NWORDS) begin : g_bad_sel
         $error("romix_sequencer: IDX_WORD out of range");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("romix_sequencer: DEPTH must be at least 2");
      end
   endgenerate

   localparam logic [AW-1:0] LAST_IT = AW'(DEPTH - 1);

   seq_state_e         st_q;
   seq_phase_e         ph_q;
   logic [STATE_W-1:0] x_q;
   logic [AW-1:0]      it_q;
   logic [STATE_W-1:0] out_q;
   logic               done_q;

   logic [HALF_W-1:0]  lo_w, hi_w;
   logic [AW-1:0]      rd_idx;
   logic               rd_fire;
   logic               second_call;
   logic               last_it;

   assign lo_w = x_q[HALF_W-1:0];
   assign hi_w = x_q[STATE_W-1:HALF_W];

   romix_index_pick #(
      .WORD_W (WORD_W),
      .DEPTH  (DEPTH)
   ) u_index (
      .word (x_q[IDX_WORD*WORD_W +: WORD_W]),
      .idx  (rd_idx)
   );

   romix_lat_timer #(
      .LAT (RD_LAT)
   ) u_rdwait (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (st_q == S_RREQ),
      .fire  (rd_fire)
   );

   // scratchpad and core drive
   assign sp_we       = (st_q == S_WRITE);
   assign sp_rd       = (st_q == S_RREQ);
   assign sp_addr     = sp_rd ? rd_idx : it_q;
   assign sp_wdata    = x_q;
   assign second_call = (st_q == S_CALL1) || (st_q == S_WAIT1);
   assign mix_start   = (st_q == S_CALL0) || (st_q == S_CALL1);
   assign mix_x       = second_call ? hi_w : lo_w;
   assign mix_y       = second_call ? lo_w : hi_w;
   assign last_it     = (it_q == LAST_IT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         ph_q   <= PH_FILL;
         x_q    <= '0;
         it_q   <= '0;
         out_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  x_q  <= state_in;
                  it_q <= '0;
                  ph_q <= PH_FILL;
                  st_q <= S_WRITE;
               end
            end
            S_WRITE: st_q <= S_CALL0;
            S_RREQ:  st_q <= S_RWAIT;
            S_RWAIT: begin
               if (rd_fire) begin
                  x_q  <= x_q ^ sp_rdata;
                  st_q <= S_CALL0;
               end
            end
            S_CALL0: st_q <= S_WAIT0;
            S_WAIT0: begin
               if (mix_done) begin
                  x_q[HALF_W-1:0] <= mix_z;
                  st_q            <= S_CALL1;
               end
            end
            S_CALL1: st_q <= S_WAIT1;
            S_WAIT1: begin
               if (mix_done) begin
                  x_q[STATE_W-1:HALF_W] <= mix_z;
                  if (last_it) begin
                     it_q <= '0;
                     if (ph_q == PH_FILL) begin
                        ph_q <= PH_MIX;
                        st_q <= S_RREQ;
                     end else begin
                        out_q  <= {mix_z, lo_w};
                        done_q <= 1'b1;
                        st_q   <= S_IDLE;
                     end
                  end else begin
                     it_q <= it_q + AW'(1);
                     st_q <= (ph_q == PH_FILL) ? S_WRITE : S_RREQ;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign state_out = out_q;
   assign done      = done_q;

   // R8: completion is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: the result only moves in the completion cycle
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(state_out));
   // R2: the second phase never writes the scratchpad
   p_no_write_in_mix_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_MIX) |-> !sp_we);
   // R4: a core call never overlaps a scratchpad access
   p_call_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mix_start |-> !(sp_we || sp_rd));
   // R4: start strobes are single cycles with a wait in between
   p_call_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mix_start |=> !mix_start);
   // R3: operands stay still while the core works
   p_operand_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mix_start |=> ($stable(mix_x) && $stable(mix_y)));

endmodule

// File: tb/romix_sequencer_bench.sv
`timescale 1ns/1ps
module romix_sequencer_bench;

   localparam int DEPTH = 16;
   localparam int LAT   = 3;
   localparam int SW    = 1024;
   localparam int HW    = 512;
   localparam int AW    = 4;
   localparam int LOGN  = 256;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [SW-1:0] state_in;
   logic [SW-1:0] state_out;
   logic          done;
   logic [AW-1:0] sp_addr;
   logic          sp_we, sp_rd;
   logic [SW-1:0] sp_wdata, sp_rdata;
   logic          mix_start;
   logic [HW-1:0] mix_x, mix_y;
   logic          mix_done;
   logic [HW-1:0] mix_z;

   always #2.5 clk = ~clk;

   romix_sequencer #(.DEPTH(DEPTH), .RD_LAT(LAT)) u_romix_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
      .state_out(state_out), .done(done), .sp_addr(sp_addr), .sp_we(sp_we),
      .sp_rd(sp_rd), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
      .mix_start(mix_start), .mix_x(mix_x), .mix_y(mix_y),
      .mix_done(mix_done), .mix_z(mix_z)
   );

   int n_chk  = 0;
   int n_fail = 0;

   function automatic logic [HW-1:0] fmix(input logic [HW-1:0] a, input logic [HW-1:0] b);
      logic [HW-1:0] t, r;
      t = a ^ b;
      for (int k = 0; k < 16; k++) begin
         logic [31:0] w, nx;
         w  = t[32*k +: 32];
         nx = t[32*((k+1)%16) +: 32];
         r[32*k +: 32] = {w[24:0], w[31:25]} + nx + 32'(k*7 + 1);
      end
      return r;
   endfunction

   // scratchpad model with fixed read latency
   logic [SW-1:0] mem  [DEPTH];
   logic [SW-1:0] pipe [LAT];
   initial for (int k = 0; k < DEPTH; k++) mem[k] = '0;
   always @(posedge clk) begin
      if (sp_we) mem[sp_addr] <= sp_wdata;
      pipe[0] <= mem[sp_addr];
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
   end
   assign sp_rdata = pipe[LAT-1];

   // mixing core model with varying response time
   int            busy_left = 0;
   int            call_n    = 0;
   int            order_err = 0;
   logic [HW-1:0] core_res;
   logic [HW-1:0] last_lo;
   always @(posedge clk) begin
      mix_done <= 1'b0;
      if (mix_done && (call_n % 2 == 1)) last_lo <= mix_z;
      if (busy_left > 0) begin
         busy_left <= busy_left - 1;
         if (busy_left == 1) begin
            mix_done <= 1'b1;
            mix_z    <= core_res;
         end
      end else if (mix_start) begin
         core_res  <= fmix(mix_x, mix_y);
         busy_left <= 1 + (call_n % 3);
         if ((call_n % 2 == 1) && (mix_y !== last_lo)) order_err <= order_err + 1;
         call_n <= call_n + 1;
      end
   end

   // port monitors
   int            wr_n = 0, rd_n = 0;
   logic [AW-1:0] wr_log [LOGN];
   logic [AW-1:0] rd_log [LOGN];
   always @(negedge clk) begin
      if (sp_we) begin
         if (wr_n < LOGN) wr_log[wr_n] = sp_addr;
         wr_n++;
      end
      if (sp_rd) begin
         if (rd_n < LOGN) rd_log[rd_n] = sp_addr;
         rd_n++;
      end
   end

   // reference model
   logic [SW-1:0] ref_mem [DEPTH];
   logic [AW-1:0] ref_idx [DEPTH];

   function automatic logic [SW-1:0] blk(input logic [SW-1:0] x);
      logic [HW-1:0] lo, hi;
      lo = fmix(x[HW-1:0], x[SW-1:HW]);
      hi = fmix(x[SW-1:HW], lo);
      return {hi, lo};
   endfunction

   task automatic ref_run(input logic [SW-1:0] x0, output logic [SW-1:0] y);
      logic [SW-1:0] x;
      x = x0;
      for (int i = 0; i < DEPTH; i++) begin
         ref_mem[i] = x;
         x = blk(x);
      end
      for (int i = 0; i < DEPTH; i++) begin
         logic [AW-1:0] j;
         j = x[HW +: AW];
         ref_idx[i] = j;
         x = blk(x ^ ref_mem[j]);
      end
      y = x;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [SW-1:0] act, input logic [SW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [SW-1:0] x);
      @(negedge clk);
      state_in = x;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      int n;
      n = 0;
      while (!done && n < 30000) begin
         @(negedge clk);
         n++;
      end
      ok = done;
   endtask

   task automatic t_reset_state;
      chk(done == 1'b0, "R1", "done after reset", SW'(done), '0);
      chk(state_out == '0, "R1", "state_out after reset", state_out, '0);
      chk(sp_we == 1'b0 && sp_rd == 1'b0, "R1", "scratchpad idle after reset",
          SW'({sp_we, sp_rd}), '0);
      chk(mix_start == 1'b0, "R1", "core idle after reset", SW'(mix_start), '0);
   endtask

   task automatic t_full_run(input logic [SW-1:0] x, input string name);
      int w0, r0, c0, e0, bad_w, bad_m, bad_r;
      bit ok;
      logic [SW-1:0] exp, got;
      w0 = wr_n; r0 = rd_n; c0 = call_n; e0 = order_err;
      ref_run(x, exp);
      pulse_start(x);
      wait_done(ok);
      got = state_out;
      chk(ok, "R8", {name, ": done seen"}, SW'(ok), SW'(1));
      chk(got == exp, "R7", {name, ": final state (R6 read timing)"}, got, exp);
      @(negedge clk);
      chk(done == 1'b0, "R8", {name, ": done one cycle"}, SW'(done), '0);
      bad_w = 0; bad_m = 0; bad_r = 0;
      for (int i = 0; i < DEPTH; i++) begin
         if (wr_log[w0 + i] != AW'(i)) bad_w++;
         if (mem[i] != ref_mem[i]) bad_m++;
         if (rd_log[r0 + i] != ref_idx[i]) bad_r++;
      end
      chk(wr_n - w0 == DEPTH, "R2", {name, ": write count"}, SW'(wr_n - w0), SW'(DEPTH));
      chk(bad_w == 0, "R2", {name, ": write order"}, SW'(bad_w), '0);
      chk(bad_m == 0, "R2", {name, ": stored states"}, SW'(bad_m), '0);
      chk(rd_n - r0 == DEPTH, "R5", {name, ": read count"}, SW'(rd_n - r0), SW'(DEPTH));
      chk(bad_r == 0, "R5", {name, ": read indices"}, SW'(bad_r), '0);
      chk(call_n - c0 == 4 * DEPTH, "R4", {name, ": core calls"}, SW'(call_n - c0),
          SW'(4 * DEPTH));
      chk(order_err == e0, "R3", {name, ": second call uses new low half"},
          SW'(order_err - e0), '0);
   endtask

   task automatic t_start_while_busy;
      logic [SW-1:0] a, b, exp;
      bit ok;
      a = {32{32'h1357_9bdf}};
      b = {32{32'hdead_0001}};
      ref_run(a, exp);
      pulse_start(a);
      repeat (40) @(negedge clk);
      pulse_start(b);
      wait_done(ok);
      chk(ok && state_out == exp, "R8", "start while busy ignored", state_out, exp);
      @(negedge clk);
   endtask

   task automatic t_hold_output;
      logic [SW-1:0] held;
      int moved;
      bit ok;
      held  = state_out;
      moved = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (state_out != held || done) moved++;
      end
      chk(moved == 0, "R8", "output held while idle", SW'(moved), '0);
      pulse_start({32{32'h0f0f_0f0f}});
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (state_out != held) moved++;
      end
      chk(moved == 0, "R8", "output held after new start", SW'(moved), '0);
      wait_done(ok);
      @(negedge clk);
   endtask

   initial begin
      logic [SW-1:0] ramp;
      rst_n    = 1'b0;
      start    = 1'b0;
      state_in = '0;
      for (int k = 0; k < 32; k++) ramp[32*k +: 32] = 32'(k * 32'h0101_0101 + 5);
      repeat (4) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_full_run('0, "zero state");
      t_full_run(ramp, "ramp state");
      t_full_run('1, "ones state");
      t_start_while_busy();
      t_hold_output();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule